// File: doc/BRIEF.md
# Vector Across-Lane Min/Max Reducer

This block folds every lane of a packed 64-bit or 128-bit SIMD operand into one scalar: the smallest or the largest lane. Lanes are 8, 16 or 32 bits wide and are compared either as unsigned numbers or as two's-complement numbers. The scalar is written to a 32-bit output port with zero extension. Encodings that are not allowed raise an undefined flag.

The controls come from one of two places, picked by `word_sel_i`. The first is a set of separate field inputs: a size code, a width bit, an unsigned bit and a minimum bit. The second is a 32-bit instruction word, which the block decodes itself. When the word is the source, the block also reports the word's source and destination register indices. A one-cycle `start_i` pulse captures the controls. Comparison is done by a combinational tree. The outcome lands in an output register, and `valid_o` rises in the next cycle.

Top module: `vred_minmax`

## Requirements
- R1: Size code 2'b00, 2'b01 and 2'b10 selects 8, 16 and 32-bit lanes, where lane k occupies operand bits [k*W+W-1 : k*W]. The result holds the selected lane's bits in its low W bits and zeros above them.
- R2: The width bit set to 1 reduces all 128 operand bits. Set to 0, it reduces only bits 63:0, and bits 127:64 have no effect on the result.
- R3: With the unsigned bit at 1, lanes are ordered as unsigned integers. At 0, they are ordered as two's-complement integers.
- R4: The minimum bit at 1 returns the smallest lane. At 0, it returns the largest.
- R5: Size code 2'b11 is undefined, and so is size code 2'b10 with the width bit at 0. An undefined request still gives a valid pulse, with `undef_o` = 1 and `result_o` = 0.
- R6: A request captured on a clock edge with `start_i` high drives `valid_o` high for exactly the following cycle. Back-to-back starts give back-to-back results. Without a start, `result_o`, `undef_o` and the register indices hold their values.
- R7: With `word_sel_i` = 1, the fields come from the word as follows: width bit = bit 30, unsigned bit = bit 29, size = bits 23:22, minimum bit = bit 16. The word matches only if bit 31 = 0, bits 28:24 = 5'b01110, bits 21:17 = 5'b11000 and bits 15:10 = 6'b101010. A word that does not match is undefined, as in R5.
- R8: `src_idx_o` reports word bits 9:5 and `dst_idx_o` reports word bits 4:0 when `word_sel_i` = 1. Both report 0 when the separate fields are used.
- R9: While reset is held, `valid_o`, `undef_o`, `result_o`, `src_idx_o` and `dst_idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture request this cycle |
| word_sel_i | input | 1 | 1: decode controls from `insn_i`; 0: use field inputs |
| insn_i | input | 32 | Instruction word |
| size_i | input | 2 | Lane size code (field source) |
| q_i | input | 1 | Width bit, 1 = 128-bit operand (field source) |
| u_i | input | 1 | Unsigned compare (field source) |
| min_i | input | 1 | Select minimum (field source) |
| data_i | input | 128 | Packed operand |
| result_o | output | 32 | Zero-extended scalar result |
| valid_o | output | 1 | Result valid strobe |
| undef_o | output | 1 | Undefined encoding flag |
| src_idx_o | output | 5 | Decoded source register index |
| dst_idx_o | output | 5 | Decoded destination register index |

## Verification
The undefined-encoding check and the reduction can both act on the same request. When they do, the flag must win, and the comparison outcome must be thrown away in that cycle. This case is provoked by illegal size and width pairs, and by corrupted fixed bits in the word. In every such case the operand has nonzero lanes, so a leaked reduction would show a nonzero result. Each result is judged in the cycle after its start against a behavioural loop model, including runs where legal and illegal requests follow each other back to back.

// File: rtl/vred_pkg.sv
package vred_pkg;
  // Size codes and their lane widths
  localparam int unsigned N_SIZES = 3;
  localparam logic [1:0] SZ_RSVD = 2'b11;
  localparam logic [1:0] SZ_W32  = 2'b10;

  function automatic int unsigned lane_bits(input int unsigned code);
    return 8 << code;
  endfunction

  typedef struct packed {
    logic       q;
    logic       u;
    logic [1:0] size;
    logic       mn;
    logic [4:0] src;
    logic [4:0] dst;
    logic       hit;
  } vred_ctl_t;
endpackage

// File: rtl/vred_decode.sv
module vred_decode
  import vred_pkg::*;
(
  input  logic [31:0] word_i,
  output vred_ctl_t   ctl_o
);
  localparam logic [4:0] TAG_HI  = 5'b01110;
  localparam logic [4:0] TAG_MID = 5'b11000;
  localparam logic [5:0] TAG_LO  = 6'b101010;

  always_comb begin
    ctl_o.q    = word_i[30];
    ctl_o.u    = word_i[29];
    ctl_o.size = word_i[23:22];
    ctl_o.mn   = word_i[16];
    ctl_o.src  = word_i[9:5];
    ctl_o.dst  = word_i[4:0];
    ctl_o.hit  = !word_i[31] && (word_i[28:24] == TAG_HI) &&
                 (word_i[21:17] == TAG_MID) && (word_i[15:10] == TAG_LO);
  end
endmodule

// File: rtl/vred_lane_tree.sv
module vred_lane_tree #(
  parameter int unsigned LW = 8,
  parameter int unsigned NL = 16
) (
  input  logic [LW*NL-1:0] lanes_i,
  input  logic             half_i,
  input  logic             signed_i,
  input  logic             min_i,
  output logic [LW-1:0]    best_o
);
  localparam int unsigned NN   = 2*NL - 1;
  localparam int unsigned HALF = NL / 2;

  logic [LW-1:0] flip;
  logic [LW-1:0] key  [NL];
  logic [LW-1:0] node [NN];

  // Signed order becomes unsigned order once the sign bit is inverted.
  assign flip = {signed_i, {(LW-1){1'b0}}};

  for (genvar g = 0; g < NL; g++) begin : g_leaf
    assign key[g] = lanes_i[g*LW +: LW] ^ flip;
    if (g >= HALF) begin : g_upper
      // Lane 0 is neutral for min/max, so it stands in for unused lanes.
      assign node[NL-1+g] = half_i ? key[0] : key[g];
    end else begin : g_lower
      assign node[NL-1+g] = key[g];
    end
  end

  for (genvar i = 0; i < NL-1; i++) begin : g_node
    logic lt;
    assign lt      = node[2*i+1] < node[2*i+2];
    assign node[i] = (min_i == lt) ? node[2*i+1] : node[2*i+2];
  end

  assign best_o = node[0] ^ flip;
endmodule

// File: rtl/vred_minmax.sv
module vred_minmax
  import vred_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned OUT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              word_sel_i,
  input  logic [31:0]       insn_i,
  input  logic [1:0]        size_i,
  input  logic              q_i,
  input  logic              u_i,
  input  logic              min_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [OUT_W-1:0]  result_o,
  output logic              valid_o,
  output logic              undef_o,
  output logic [4:0]        src_idx_o,
  output logic [4:0]        dst_idx_o
);
  vred_ctl_t dec;
  vred_ctl_t ctl;
  logic [OUT_W-1:0] tree_res [N_SIZES];
  logic             bad;
  logic [OUT_W-1:0] res_d;
  logic [4:0]       src_d, dst_d;

  logic [OUT_W-1:0] res_q;
  logic             valid_q, undef_q;
  logic [4:0]       src_q, dst_q;

  vred_decode u_dec (.word_i(insn_i), .ctl_o(dec));

  always_comb begin
    if (word_sel_i) begin
      ctl = dec;
    end else begin
      ctl      = '0;
      ctl.q    = q_i;
      ctl.u    = u_i;
      ctl.size = size_i;
      ctl.mn   = min_i;
      ctl.hit  = 1'b1;
    end
  end

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    localparam int unsigned LW = lane_bits(s);
    localparam int unsigned NL = DATA_W / LW;
    logic [LW-1:0] best;

    vred_lane_tree #(.LW(LW), .NL(NL)) u_tree (
      .lanes_i (data_i),
      .half_i  (!ctl.q),
      .signed_i(!ctl.u),
      .min_i   (ctl.mn),
      .best_o  (best)
    );

    always_comb begin
      tree_res[s]         = '0;
      tree_res[s][LW-1:0] = best;
    end
  end

  // Next-state logic
  always_comb begin
    bad = !ctl.hit || (ctl.size == SZ_RSVD) || (ctl.size == SZ_W32 && !ctl.q);
    case (ctl.size)
      2'b00:   res_d = tree_res[0];
      2'b01:   res_d = tree_res[1];
      2'b10:   res_d = tree_res[2];
      default: res_d = '0;
    endcase
    if (bad) res_d = '0;
    src_d = ctl.src;
    dst_d = ctl.dst;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      undef_q <= 1'b0;
      res_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
    end else begin
      valid_q <= start_i;
      if (start_i) begin
        undef_q <= bad;
        res_q   <= res_d;
        src_q   <= src_d;
        dst_q   <= dst_d;
      end
    end
  end

  assign result_o  = res_q;
  assign valid_o   = valid_q;
  assign undef_o   = undef_q;
  assign src_idx_o = src_q;
  assign dst_idx_o = dst_q;
endmodule

// File: rtl/vred_minmax_chk.sv
module vred_minmax_chk #(
  parameter int unsigned OUT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             word_sel_i,
  input logic [31:0]      insn_i,
  input logic [1:0]       size_i,
  input logic [OUT_W-1:0] result_o,
  input logic             valid_o,
  input logic             undef_o
);
  a_r6_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(result_o) && $stable(undef_o)));

  a_r5_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && undef_o) |-> (result_o == '0));

  a_r5_rsvd_size: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !word_sel_i && size_i == 2'b11) |=> undef_o);

  a_r1_byte_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !word_sel_i && size_i == 2'b00) |=> (result_o[OUT_W-1:8] == '0));

  a_r7_bad_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && word_sel_i && insn_i[31]) |=> undef_o);
endmodule

bind vred_minmax vred_minmax_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .word_sel_i(word_sel_i),
  .insn_i    (insn_i),
  .size_i    (size_i),
  .result_o  (result_o),
  .valid_o   (valid_o),
  .undef_o   (undef_o)
);

// File: tb/sim_vred_minmax.sv
module sim_vred_minmax;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i, word_sel_i, q_i, u_i, min_i;
  logic [31:0]  insn_i;
  logic [1:0]   size_i;
  logic [127:0] data_i;
  logic [31:0]  result_o;
  logic         valid_o, undef_o;
  logic [4:0]   src_idx_o, dst_idx_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vred_minmax u0 (.*);

  task automatic chk(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: sequential fold from lane 0 upward.
  function automatic longint ref_red(logic [127:0] d, int sz, bit q, bit u, bit mn);
    int     esz, n;
    longint acc, el, msk;
    if (sz == 3 || (sz == 2 && !q)) return 0;
    esz = 8 << sz;
    n   = (64 << q) / esz;
    msk = (longint'(1) << esz) - 1;
    for (int e = 0; e < n; e++) begin
      el = longint'((d >> (e*esz)) & 128'(msk));
      if (!u && el[esz-1]) el = el - (longint'(1) << esz);
      if (e == 0) acc = el;
      else if (mn) acc = (el < acc) ? el : acc;
      else acc = (el > acc) ? el : acc;
    end
    return acc & msk;
  endfunction

  function automatic logic [31:0] mk_word(bit q, bit u, logic [1:0] sz, bit mn,
                                          logic [4:0] rn, logic [4:0] rd);
    return {1'b0, q, u, 5'b01110, sz, 5'b11000, mn, 6'b101010, rn, rd};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Called at a negedge; leaves start high so consecutive calls are back to back.
  task automatic run_op(bit ws, logic [31:0] w, logic [1:0] sz, bit q, bit u, bit mn,
                        logic [127:0] d, string req);
    bit     hit;
    int     esz;
    longint exp_r;
    bit     exp_u;
    start_i = 1'b1; word_sel_i = ws; insn_i = w;
    size_i = sz; q_i = q; u_i = u; min_i = mn; data_i = d;
    if (ws) begin
      hit = !w[31] && w[28:24] == 5'b01110 && w[21:17] == 5'b11000 && w[15:10] == 6'b101010;
      sz = w[23:22]; q = w[30]; u = w[29]; mn = w[16];
    end else hit = 1'b1;
    exp_u = !hit || sz == 2'b11 || (sz == 2'b10 && !q);
    exp_r = exp_u ? 0 : ref_red(d, int'(sz), q, u, mn);
    @(negedge clk);
    chk({req, " valid"}, longint'(valid_o), 1);
    chk({req, " undef"}, longint'(undef_o), longint'(exp_u));
    chk({req, " result"}, longint'(result_o), exp_r);
    chk("R8 src", longint'(src_idx_o), ws ? longint'(w[9:5]) : 0);
    chk("R8 dst", longint'(dst_idx_o), ws ? longint'(w[4:0]) : 0);
  endtask

  task automatic idle_check();
    logic [31:0] r;
    bit          un;
    r = result_o; un = undef_o;
    start_i = 1'b0;
    data_i  = rnd128();
    size_i  = 2'b00;
    @(negedge clk);
    chk("R6 idle valid", longint'(valid_o), 0);
    chk("R6 idle hold", longint'(result_o), longint'(r));
    chk("R6 idle undef hold", longint'(undef_o), longint'(un));
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; word_sel_i = 1'b0; insn_i = '0;
    size_i = '0; q_i = 1'b0; u_i = 1'b0; min_i = 1'b0; data_i = '0;
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    chk("R9 reset valid", longint'(valid_o), 0);
    chk("R9 reset result", longint'(result_o), 0);
    chk("R9 reset undef", longint'(undef_o), 0);
    chk("R9 reset idx", longint'({src_idx_o, dst_idx_o}), 0);
    start_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    run_op(0, 0, 2'b00, 1, 0, 0, {16{8'h7F}} ^ {15'd0, 1'b1, 112'd0}, "R3 signed max equal-ish");
    run_op(0, 0, 2'b00, 1, 0, 1, {{15{8'h7F}}, 8'h80}, "R3 signed min 0x80");
    run_op(0, 0, 2'b00, 1, 1, 1, {{15{8'h7F}}, 8'h80}, "R3 unsigned min");
    run_op(0, 0, 2'b00, 0, 1, 0, {{8{8'hFF}}, {8{8'h00}}}, "R2 upper half ignored");
    run_op(0, 0, 2'b01, 1, 1, 0, {{7{16'h0001}}, 16'hFFFF}, "R1 half lane");
    run_op(0, 0, 2'b10, 1, 0, 1, {32'h8000_0000, 96'd5}, "R4 signed word min");
    run_op(0, 0, 2'b10, 0, 1, 0, {128{1'b1}}, "R5 word lanes narrow");
    run_op(0, 0, 2'b11, 1, 1, 1, {128{1'b1}}, "R5 reserved size");
    idle_check();

    // Every legal and illegal field combination with random operands
    for (int sz = 0; sz < 4; sz++)
      for (int q = 0; q < 2; q++)
        for (int u = 0; u < 2; u++)
          for (int mn = 0; mn < 2; mn++) begin
            for (int k = 0; k < 12; k++)
              run_op(0, 0, 2'(sz), q[0], u[0], mn[0], rnd128(), "R1 R2 R3 R4 R5 fields");
            idle_check();
          end

    // Decoded words, including corrupted fixed bits
    for (int k = 0; k < 150; k++) begin
      logic [31:0] w;
      w = mk_word($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                  2'($urandom_range(0, 3)), $urandom_range(0, 1) == 1,
                  5'($urandom), 5'($urandom));
      if (k % 4 == 3) w[$urandom_range(10, 31)] ^= 1'b1;
      run_op(1, w, 2'b00, 1, 1, 1, rnd128(), "R7 word decode");
      if (k % 10 == 9) idle_check();
    end
    run_op(1, mk_word(1, 1, 2'b00, 0, 5'd17, 5'd3) | 32'h8000_0000,
           2'b00, 1, 1, 0, {128{1'b1}}, "R7 top bit set");
    idle_check();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule